// File: doc/BRIEF.md
# Self-Timed EEPROM Programming Sequencer

This block runs the programming cycles of a small 256-bit nonvolatile array, held here as a register array of sixteen 16-bit words. The same storage can be organized as sixteen words or thirty-two bytes, chosen by a mode input. A serial front end decodes commands and hands them over as single-cycle requests. Each request marks the moment chip select falls after the last address or data bit. The sequencer keeps the erase/write enable latch. It accepts erase, write, erase-all and write-all requests only while that latch is set. Each accepted request starts a timed busy period counted in clock ticks, and the array is updated when the period ends.

A single-location write clears the target location first, so the stored result is exactly the new data. Write-all skips that clear, so every location ends up as its old contents ANDed with the supplied pattern. The ready output is the status bit the front end returns on its data line: 0 while a cycle runs and 1 otherwise. The read port is combinational and does not depend on the enable latch.

The controller has two states. ST_IDLE takes requests. The transition IDLE->BUSY happens when a program request arrives while the latch is set. ST_BUSY ignores all requests. The transition BUSY->IDLE happens on the terminal tick of the cycle timer, in the same edge that commits the update to the array.

Top module: `eeprom_prog_seq`

## Requirements
- R1: After reset, ready is 1, the enable latch is cleared and every array bit reads 1.
- R2: Request codes are 1 = enable, 2 = disable, 3 = erase, 4 = write, 5 = erase-all and 6 = write-all. Enable sets the latch and disable clears it, both without a busy period. Codes 0 and 7 change nothing.
- R3: A program request (codes 3 to 6) received while the latch is cleared is ignored: ready stays 1 and the array is unchanged.
- R4: Erase sets the addressed location to all ones. In word mode, addr[3:0] selects the word. In byte mode, byte A lives in word A[4:1], in bits [15:8] when A[0]=1 and in bits [7:0] when A[0]=0, and the other byte of that word is left untouched.
- R5: A single write leaves the location equal to the new data whatever it held before. Byte mode uses data[7:0].
- R6: Erase-all sets every bit of the array to 1.
- R7: Write-all leaves every location equal to its old contents AND the pattern. In byte mode the pattern is data[7:0], applied to both bytes of each word.
- R8: Ready falls on the first edge after an accepted program request and stays 0 for exactly CYCLE_TICKS cycles. Reads during that time return the old contents, and the new contents appear when ready returns to 1.
- R9: Any request received while busy is dropped. That includes enable and disable, so neither the array nor the latch changes.
- R10: Reads return the array contents whatever the latch state. In byte mode the selected byte is returned zero-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the cycle timer counts its edges |
| rst_n | input | 1 | Active-low power-on reset |
| org_byte | input | 1 | 1 = 32 x 8 organization, 0 = 16 x 16 |
| req_valid | input | 1 | One-cycle pulse carrying a decoded request |
| req_op | input | 3 | Request code (see R2) |
| req_addr | input | 5 | Byte or word address |
| req_data | input | 16 | Data for write or write-all |
| rd_addr | input | 5 | Read address |
| rd_data | output | 16 | Read data, zero-extended in byte mode |
| ready | output | 1 | Status: 1 ready, 0 busy |

## Verification
A timer that stops early or late shows up at once as a busy period of the wrong length on ready. A stuck controller state shows up as ready never returning. A wrong enable latch is not visible on any pin until the next program request: that request then starts or fails to start a cycle, and the array contents differ once that cycle would have ended. A wrong lane or mask selection only shows up in a read of the neighbouring byte or word after the commit, so the bench reads back the whole array after every operation.

// File: rtl/eeprom_prog_pkg.sv
package eeprom_prog_pkg;
    parameter int WORD_W    = 16;
    parameter int NUM_WORDS = 16;
    localparam int BYTE_W   = WORD_W / 2;
    localparam int WIDX_W   = $clog2(NUM_WORDS);
    localparam int BADDR_W  = WIDX_W + 1;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_EN    = 3'd1,
        OP_DIS   = 3'd2,
        OP_ERASE = 3'd3,
        OP_WRITE = 3'd4,
        OP_ERAL  = 3'd5,
        OP_WRAL  = 3'd6,
        OP_RSVD  = 3'd7
    } prog_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } seq_state_e;

    typedef struct packed {
        prog_op_e             op;
        logic [BADDR_W-1:0]   addr;
        logic [WORD_W-1:0]    data;
        logic                 org_byte;
    } prog_req_t;
endpackage

// File: rtl/prog_cycle_timer.sv
module prog_cycle_timer #(
    parameter int CYCLE_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic running,
    output logic done
);
    localparam int CNT_W = (CYCLE_TICKS > 2) ? $clog2(CYCLE_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q) begin
            if (cnt_q == LAST) begin
                run_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        running = run_q;
        done    = run_q && (cnt_q == LAST);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q <= LAST)); // R8
endmodule

// File: rtl/prog_lane_decode.sv
module prog_lane_decode
    import eeprom_prog_pkg::*;
(
    input  prog_req_t             req,
    output logic                  all_words,
    output logic [WIDX_W-1:0]     word_idx,
    output logic [WORD_W-1:0]     bit_mask,
    output logic [WORD_W-1:0]     bit_val,
    output logic                  and_mode
);
    logic [WORD_W-1:0] lane_mask;
    logic [WORD_W-1:0] fill;

    always_comb begin
        if (req.org_byte) begin
            word_idx  = req.addr[BADDR_W-1:1];
            lane_mask = req.addr[0] ? {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}}
                                    : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
            fill      = {req.data[BYTE_W-1:0], req.data[BYTE_W-1:0]};
        end else begin
            word_idx  = req.addr[WIDX_W-1:0];
            lane_mask = '1;
            fill      = req.data;
        end
    end

    always_comb begin
        all_words = 1'b0;
        bit_mask  = '0;
        bit_val   = '1;
        and_mode  = 1'b0;
        unique case (req.op)
            OP_ERASE: begin
                bit_mask = lane_mask;
            end
            OP_WRITE: begin
                bit_mask = lane_mask;
                bit_val  = fill;
            end
            OP_ERAL: begin
                all_words = 1'b1;
                bit_mask  = '1;
            end
            OP_WRAL: begin
                all_words = 1'b1;
                bit_mask  = '1;
                bit_val   = fill;
                and_mode  = 1'b1;
            end
            default: begin
                bit_mask = '0;
            end
        endcase
    end
endmodule

// File: rtl/prog_cell_array.sv
module prog_cell_array
    import eeprom_prog_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit,
    input  logic                  all_words,
    input  logic [WIDX_W-1:0]     word_idx,
    input  logic [WORD_W-1:0]     bit_mask,
    input  logic [WORD_W-1:0]     bit_val,
    input  logic                  and_mode,
    input  logic [WIDX_W-1:0]     rd_idx,
    output logic [WORD_W-1:0]     rd_word
);
    logic [WORD_W-1:0] cells [NUM_WORDS];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        logic              hit;
        logic [WORD_W-1:0] next_bits;

        always_comb begin
            hit       = all_words || (word_idx == WIDX_W'(g));
            next_bits = and_mode ? (cells[g] & bit_val) : bit_val;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cells[g] <= '1;
            end else if (commit && hit) begin
                cells[g] <= (cells[g] & ~bit_mask) | (next_bits & bit_mask);
            end
        end
    end

    always_comb rd_word = cells[rd_idx];
endmodule

// File: rtl/eeprom_prog_seq.sv
module eeprom_prog_seq
    import eeprom_prog_pkg::*;
#(
    parameter int CYCLE_TICKS = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                org_byte,
    input  logic                req_valid,
    input  logic [2:0]          req_op,
    input  logic [BADDR_W-1:0]  req_addr,
    input  logic [WORD_W-1:0]   req_data,
    input  logic [BADDR_W-1:0]  rd_addr,
    output logic [WORD_W-1:0]   rd_data,
    output logic                ready
);
    seq_state_e state_q, state_d;
    logic       wen_q;
    prog_req_t  pend_q;
    prog_op_e   op_in;
    logic       accept, is_prog, launch, commit;
    logic       tmr_run, tmr_done;

    logic                all_words, and_mode;
    logic [WIDX_W-1:0]   word_idx, rd_idx;
    logic [WORD_W-1:0]   bit_mask, bit_val, rd_word;

    always_comb begin
        op_in   = prog_op_e'(req_op);
        accept  = req_valid && (state_q == ST_IDLE);
        is_prog = (op_in == OP_ERASE) || (op_in == OP_WRITE) ||
                  (op_in == OP_ERAL)  || (op_in == OP_WRAL);
        launch  = accept && is_prog && wen_q;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch)   state_d = ST_BUSY;
            ST_BUSY: if (tmr_done) state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        ready  = (state_q == ST_IDLE);
        commit = (state_q == ST_BUSY) && tmr_done;
    end

    // enable latch and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wen_q  <= 1'b0;
            pend_q <= '0;
        end else begin
            if (accept && op_in == OP_EN)  wen_q <= 1'b1;
            if (accept && op_in == OP_DIS) wen_q <= 1'b0;
            if (launch) begin
                pend_q.op       <= op_in;
                pend_q.addr     <= req_addr;
                pend_q.data     <= req_data;
                pend_q.org_byte <= org_byte;
            end
        end
    end

    prog_cycle_timer #(.CYCLE_TICKS(CYCLE_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (launch),
        .running (tmr_run),
        .done    (tmr_done)
    );

    prog_lane_decode u_decode (
        .req       (pend_q),
        .all_words (all_words),
        .word_idx  (word_idx),
        .bit_mask  (bit_mask),
        .bit_val   (bit_val),
        .and_mode  (and_mode)
    );

    prog_cell_array u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .all_words (all_words),
        .word_idx  (word_idx),
        .bit_mask  (bit_mask),
        .bit_val   (bit_val),
        .and_mode  (and_mode),
        .rd_idx    (rd_idx),
        .rd_word   (rd_word)
    );

    // read path, independent of the enable latch
    always_comb begin
        if (org_byte) begin
            rd_idx  = rd_addr[BADDR_W-1:1];
            rd_data = rd_addr[0] ? {{BYTE_W{1'b0}}, rd_word[WORD_W-1:BYTE_W]}
                                 : {{BYTE_W{1'b0}}, rd_word[BYTE_W-1:0]};
        end else begin
            rd_idx  = rd_addr[WIDX_W-1:0];
            rd_data = rd_word;
        end
    end

    AST_LOCKED_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready && !wen_q) |=> ready); // R3
    AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(req_valid)); // R8
    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !tmr_done) |=> !ready); // R8
    AST_RELEASE_ON_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(tmr_done)); // R8
    AST_TIMER_MATCHES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> tmr_run); // R8
    AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(wen_q)); // R9
endmodule

// File: tb/test_eeprom_prog_seq.sv
`timescale 1ns/1ps
module test_eeprom_prog_seq;
    localparam int TICKS = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        org_byte = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [4:0]  req_addr = 5'd0;
    logic [15:0] req_data = 16'd0;
    logic [4:0]  rd_addr = 5'd0;
    logic [15:0] rd_data;
    logic        ready;

    always #2.5 clk = ~clk;

    eeprom_prog_seq #(.CYCLE_TICKS(TICKS)) i_eeprom_prog_seq (
        .clk(clk), .rst_n(rst_n), .org_byte(org_byte),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready)
    );

    typedef struct {
        logic [4:0]  a;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t       sbq[$];
    int          checks = 0;
    int          errors = 0;
    logic [15:0] mw [16];
    logic        m_wen = 1'b0;

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(logic [4:0] a, logic ob);
        if (ob) return a[0] ? {8'h00, mw[a[4:1]][15:8]} : {8'h00, mw[a[4:1]][7:0]};
        return mw[a[3:0]];
    endfunction

    // monitor: pops expected reads and compares them
    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                it = sbq.pop_front();
                rd_addr = it.a;
                #1;
                check(it.tag, rd_data, it.exp);
            end
        end
    end

    task automatic push_all(string tag);
        int n;
        n = org_byte ? 32 : 16;
        for (int i = 0; i < n; i++) sbq.push_back('{5'(i), exp_read(5'(i), org_byte), tag});
        while (sbq.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send(logic [2:0] op, logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd0;
    endtask

    task automatic model_apply(logic [2:0] op, logic [4:0] a, logic [15:0] d);
        logic [15:0] fill;
        fill = org_byte ? {d[7:0], d[7:0]} : d;
        case (op)
            3'd3: if (org_byte) begin
                      if (a[0]) mw[a[4:1]][15:8] = 8'hFF; else mw[a[4:1]][7:0] = 8'hFF;
                  end else mw[a[3:0]] = 16'hFFFF;
            3'd4: if (org_byte) begin
                      if (a[0]) mw[a[4:1]][15:8] = d[7:0]; else mw[a[4:1]][7:0] = d[7:0];
                  end else mw[a[3:0]] = d;
            3'd5: for (int i = 0; i < 16; i++) mw[i] = 16'hFFFF;
            3'd6: for (int i = 0; i < 16; i++) mw[i] = mw[i] & fill;
            default: ;
        endcase
    endtask

    // driver: issues a request to an idle block and updates the model
    task automatic run_cmd(logic [2:0] op, logic [4:0] a, logic [15:0] d,
                           string tag, bit peek_old = 1'b0);
        bit prog;
        int n;
        prog = (op >= 3'd3) && (op <= 3'd6);
        send(op, a, d);
        if (prog && m_wen) begin
            check({tag, " R8 busy start"}, {15'd0, ready}, 16'd0);
            if (peek_old) sbq.push_back('{a, exp_read(a, org_byte), "R8 old data while busy"});
            n = 0;
            while (!ready && n < 1000) begin n++; @(negedge clk); end
            check({tag, " R8 busy length"}, 16'(n), 16'(TICKS));
            model_apply(op, a, d);
        end else begin
            check({tag, " no cycle"}, {15'd0, ready}, 16'd1);
            if (op == 3'd1) m_wen = 1'b1;
            if (op == 3'd2) m_wen = 1'b0;
        end
        push_all(tag);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int n;
        for (int i = 0; i < 16; i++) mw[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", {15'd0, ready}, 16'd1);
        push_all("R1 array all ones");

        // R3: latch cleared at reset, write ignored
        run_cmd(3'd4, 5'd3, 16'h1234, "R3 write while locked");
        // R2: enable, then a word write with a read during busy (R8)
        run_cmd(3'd1, 5'd0, 16'h0000, "R2 enable");
        run_cmd(3'd4, 5'd3, 16'hA5C3, "R5 word write", 1'b1);
        run_cmd(3'd4, 5'd3, 16'h0F3C, "R5 overwrite auto erase");
        run_cmd(3'd3, 5'd3, 16'h0000, "R4 word erase");
        run_cmd(3'd4, 5'd15, 16'h8001, "R5 top word");

        // R9: requests while busy are dropped, latch kept
        send(3'd4, 5'd7, 16'h1111);
        send(3'd2, 5'd0, 16'h0000);
        send(3'd4, 5'd8, 16'h2222);
        n = 0;
        while (!ready && n < 1000) begin n++; @(negedge clk); end
        model_apply(3'd4, 5'd7, 16'h1111);
        push_all("R9 dropped write");
        run_cmd(3'd4, 5'd9, 16'h3333, "R9 latch still set");

        // R2: codes 0 and 7 change nothing
        run_cmd(3'd0, 5'd9, 16'h0000, "R2 code 0");
        run_cmd(3'd7, 5'd9, 16'h0000, "R2 code 7");
        run_cmd(3'd4, 5'd10, 16'h4444, "R2 latch unaffected by code 7");

        // R6, R7 word mode
        run_cmd(3'd5, 5'd0, 16'h0000, "R6 erase all");
        run_cmd(3'd6, 5'd0, 16'h3C3C, "R7 write all");
        run_cmd(3'd6, 5'd0, 16'h0FF0, "R7 write all ANDs");

        // byte mode: R4, R5, R7
        org_byte = 1'b1;
        run_cmd(3'd5, 5'd0, 16'h0000, "R6 erase all byte mode");
        run_cmd(3'd4, 5'd5, 16'hEE5A, "R5 byte write odd");
        run_cmd(3'd4, 5'd4, 16'h11C3, "R5 byte write even");
        run_cmd(3'd3, 5'd5, 16'h0000, "R4 byte erase keeps neighbour");
        run_cmd(3'd6, 5'd0, 16'h0081, "R7 byte write all");

        // R10: reads unaffected by latch; R3 after disable
        run_cmd(3'd2, 5'd0, 16'h0000, "R10 disable then read");
        run_cmd(3'd5, 5'd0, 16'h0000, "R3 erase all while locked");
        org_byte = 1'b0;
        push_all("R10 word view while locked");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule